// File: doc/BRIEF.md
# Truncating float-to-integer converter

This block takes a floating-point operand that has already been unpacked into sign, class, unbiased exponent and an explicit mantissa. It produces a signed two's-complement integer, always rounding toward zero whatever rounding mode the surrounding unit is using. Results that do not fit are clamped to the integer range. Two flags come back with each result: one reports that fractional bits were lost, the other reports an invalid conversion.

The parameter `W` picks a 32-bit or 64-bit result. The mantissa is `W+4` bits wide. Bit `W+1` holds the leading one and the two bits above it are zero. Below the integer span sit two extra low bits, and a separate sticky input summarises anything further down. An operand is accepted on any cycle that has `in_valid` high, and its result is registered one clock later together with `out_valid`.

Top module: `fti_trunc_conv`

## Requirements
- R1: An operand of class code 0 (zero), of either sign, produces result 0 with both flags clear.
- R2: An operand of class code 1 (number) whose unbiased exponent is W or more is an overflow.
- R3: Class codes 2 (infinity), 3 (quiet NaN) and 4 (signalling NaN) are always treated as overflow, whatever the exponent or mantissa.
- R4: For a number, the mantissa value is in_mant × 2^(in_exp − (W+1)). The magnitude returned is the integer part of that value, so the fraction is simply dropped.
- R5: out_inexact is set on a non-overflowing number when in_sticky is set or any mantissa bit below the integer part is nonzero. A number with a negative exponent therefore gives 0 with out_inexact set.
- R6: A magnitude of 2^(W−1) overflows for a positive operand but is accepted for a negative one, giving the most negative integer. Any larger magnitude overflows for both signs.
- R7: An overflow sets out_invalid, clears out_inexact, and returns 2^(W−1)−1 for a positive operand or −2^(W−1) for a negative one.
- R8: A non-overflowing negative number returns the two's-complement negation of its magnitude, and a positive one never returns a value with the top bit set.
- R9: out_valid is high exactly one cycle after in_valid. After reset, out_valid and the result are 0. The result holds while no operand is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand present this cycle |
| in_sign | input | 1 | Operand sign, 1 = negative |
| in_class | input | 3 | Class code: 0 zero, 1 number, 2 infinity, 3 quiet NaN, 4 signalling NaN |
| in_exp | input | EXP_W | Signed unbiased exponent |
| in_mant | input | W+4 | Mantissa, leading one at bit W+1, two low extra bits |
| in_sticky | input | 1 | OR of all bits below the mantissa |
| out_valid | output | 1 | Result present |
| out_result | output | W | Signed integer result |
| out_inexact | output | 1 | Fractional bits were discarded |
| out_invalid | output | 1 | Conversion overflowed or the operand was not a number |

## Verification
The properties assume that every operand of class code 1 is normalised: bit W+1 is one, the two bits above it are zero, and the exponent fits in EXP_W bits. Under that assumption a negative exponent always discards a nonzero bit. The stimulus therefore builds every number-class mantissa with the top two bits forced to zero and the leading one forced on, and it draws exponents only from a narrow signed range. Operands of the other classes carry arbitrary mantissa bits, which shows that those bits are ignored.

// File: rtl/fti_pkg.sv
package fti_pkg;

   typedef enum logic [2:0] {
      FC_ZERO = 3'd0,
      FC_NUM  = 3'd1,
      FC_INF  = 3'd2,
      FC_QNAN = 3'd3,
      FC_SNAN = 3'd4
   } fcls_e;

endpackage

// File: rtl/fti_align.sv
// Moves the integer part of the mantissa into the low W bits and ORs every
// discarded bit (plus the incoming sticky) into a single lost flag.
module fti_align #(
   parameter int W     = 32,
   parameter int EXP_W = 12
) (
   input  logic [W+3:0]             mant,
   input  logic signed [EXP_W-1:0]  exp,
   input  logic                     sticky,
   output logic [W-1:0]             mag,
   output logic                     lost
);
   localparam int MW   = W + 4;
   localparam int LEAD = W + 1;
   localparam int SHW  = $clog2(MW + 1);
   localparam int SFW  = EXP_W + 2;

   logic signed [SFW-1:0] sh_full;
   logic [SHW-1:0]        sh;
   logic [MW-1:0]         lost_vec;

   assign sh_full = SFW'(LEAD) - {{2{exp[EXP_W-1]}}, exp};

   // Negative shift means an exponent far above range (flagged elsewhere);
   // shifts of MW or more push every bit into the lost flag.
   always_comb begin
      if (sh_full[SFW-1])
         sh = '0;
      else if (sh_full >= $signed(SFW'(MW)))
         sh = SHW'(MW);
      else
         sh = sh_full[SHW-1:0];
   end

   assign mag = W'(mant >> sh);

   for (genvar i = 0; i < MW; i++) begin : g_lost
      assign lost_vec[i] = mant[i] && (SHW'(i) < sh);
   end

   assign lost = (|lost_vec) | sticky;

endmodule

// File: rtl/fti_range.sv
// Decides whether the operand cannot be represented in a W-bit signed integer.
module fti_range
   import fti_pkg::*;
#(
   parameter int W     = 32,
   parameter int EXP_W = 12
) (
   input  fcls_e                    cls,
   input  logic                     sign,
   input  logic signed [EXP_W-1:0]  exp,
   input  logic [W-1:0]             mag,
   output logic                     ovf
);
   logic not_number;
   logic exp_big;
   logic mag_big;

   assign not_number = (cls != FC_ZERO) && (cls != FC_NUM);
   assign exp_big    = exp >= EXP_W'(W);
   // Top bit set: only -2^(W-1) exactly still fits.
   assign mag_big    = mag[W-1] && !(sign && (mag[W-2:0] == '0));
   assign ovf        = not_number || ((cls == FC_NUM) && (exp_big || mag_big));

endmodule

// File: rtl/fti_pack.sv
// Applies sign, clamps on overflow and selects the flags.
module fti_pack
   import fti_pkg::*;
#(
   parameter int W = 32
) (
   input  fcls_e          cls,
   input  logic           sign,
   input  logic [W-1:0]   mag,
   input  logic           lost,
   input  logic           ovf,
   output logic [W-1:0]   result,
   output logic           inexact,
   output logic           invalid
);
   localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};
   localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};

   always_comb begin
      result  = '0;
      inexact = 1'b0;
      invalid = 1'b0;
      if (ovf) begin
         result  = sign ? NEG_LIM : POS_LIM;
         invalid = 1'b1;
      end else if (cls == FC_NUM) begin
         result  = sign ? (~mag + ONE) : mag;
         inexact = lost;
      end
   end

endmodule

// File: rtl/fti_trunc_conv.sv
module fti_trunc_conv
   import fti_pkg::*;
#(
   parameter int W     = 32,
   parameter int EXP_W = 12
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic                     in_sign,
   input  logic [2:0]               in_class,
   input  logic signed [EXP_W-1:0]  in_exp,
   input  logic [W+3:0]             in_mant,
   input  logic                     in_sticky,
   output logic                     out_valid,
   output logic [W-1:0]             out_result,
   output logic                     out_inexact,
   output logic                     out_invalid
);
   if (W != 32 && W != 64) begin : g_bad_width
      initial $fatal(1, "fti_trunc_conv: W must be 32 or 64");
   end
   if (EXP_W < $clog2(W) + 2) begin : g_bad_exp
      initial $fatal(1, "fti_trunc_conv: EXP_W too narrow for W");
   end

   fcls_e          cls;
   logic [W-1:0]   mag;
   logic           lost;
   logic           ovf;
   logic [W-1:0]   res_d;
   logic           inx_d;
   logic           inv_d;

   assign cls = fcls_e'(in_class);

   fti_align #(.W(W), .EXP_W(EXP_W)) u_align (
      .mant   (in_mant),
      .exp    (in_exp),
      .sticky (in_sticky),
      .mag    (mag),
      .lost   (lost)
   );

   fti_range #(.W(W), .EXP_W(EXP_W)) u_range (
      .cls  (cls),
      .sign (in_sign),
      .exp  (in_exp),
      .mag  (mag),
      .ovf  (ovf)
   );

   fti_pack #(.W(W)) u_pack (
      .cls     (cls),
      .sign    (in_sign),
      .mag     (mag),
      .lost    (lost),
      .ovf     (ovf),
      .result  (res_d),
      .inexact (inx_d),
      .invalid (inv_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_result  <= '0;
         out_inexact <= 1'b0;
         out_invalid <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_result  <= res_d;
            out_inexact <= inx_d;
            out_invalid <= inv_d;
         end
      end
   end

endmodule

// File: rtl/fti_trunc_conv_chk.sv
module fti_trunc_conv_chk #(
   parameter int W     = 32,
   parameter int EXP_W = 12
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     in_valid,
   input logic                     in_sign,
   input logic [2:0]               in_class,
   input logic signed [EXP_W-1:0]  in_exp,
   input logic                     out_valid,
   input logic [W-1:0]             out_result,
   input logic                     out_inexact,
   input logic                     out_invalid
);
   p_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_class == 3'd0) |=> (out_result == '0 && !out_inexact && !out_invalid));

   p_bigexp_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_class == 3'd1 && in_exp >= EXP_W'(W)) |=> out_invalid);

   p_special_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (in_class == 3'd2 || in_class == 3'd3 || in_class == 3'd4)) |=> out_invalid);

   p_fraction_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_class == 3'd1 && in_exp < 0) |=> (out_result == '0 && out_inexact));

   p_flag_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !(out_invalid && out_inexact));

   p_sat_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_invalid) |-> (out_result[W-2:0] == {(W-1){~out_result[W-1]}}));

   p_pos_sign_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_class == 3'd1 && !in_sign) |=> !out_result[W-1]);

   p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(out_result)));

endmodule

bind fti_trunc_conv fti_trunc_conv_chk #(.W(W), .EXP_W(EXP_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .in_sign     (in_sign),
   .in_class    (in_class),
   .in_exp      (in_exp),
   .out_valid   (out_valid),
   .out_result  (out_result),
   .out_inexact (out_inexact),
   .out_invalid (out_invalid)
);

// File: tb/fti_trunc_conv_tb.sv
`timescale 1ns/1ps
module fti_trunc_conv_tb;
   localparam int W     = 32;
   localparam int EXP_W = 12;
   localparam int MW    = W + 4;

   typedef struct {
      logic [W-1:0] res;
      logic         inx;
      logic         inv;
      string        tag;
   } exp_t;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    in_valid = 1'b0;
   logic                    in_sign = 1'b0;
   logic [2:0]              in_class = 3'd0;
   logic signed [EXP_W-1:0] in_exp = '0;
   logic [MW-1:0]           in_mant = '0;
   logic                    in_sticky = 1'b0;
   logic                    out_valid;
   logic [W-1:0]            out_result;
   logic                    out_inexact;
   logic                    out_invalid;

   int   n_cmp = 0;
   int   n_bad = 0;
   int   cyc   = 0;
   bit   done  = 1'b0;
   exp_t q[$];

   always #4 clk = ~clk;

   fti_trunc_conv #(.W(W), .EXP_W(EXP_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
      .in_class(in_class), .in_exp(in_exp), .in_mant(in_mant),
      .in_sticky(in_sticky), .out_valid(out_valid), .out_result(out_result),
      .out_inexact(out_inexact), .out_invalid(out_invalid)
   );

   // Behavioural reference built straight from the requirements.
   function automatic exp_t model(bit sgn, int cls, int e, logic [MW-1:0] m, bit stk);
      exp_t r;
      logic [MW-1:0] half;
      logic [MW-1:0] mg;
      bit            lst;
      bit            ovf;
      int            sh;
      half = '0;
      half[W-1] = 1'b1;
      r.res = '0; r.inx = 1'b0; r.inv = 1'b0;
      ovf = 1'b0;
      if (cls == 0) begin
         r.tag = "R1";
         return r;
      end
      if (cls != 1) begin
         r.tag = "R3+R7";
         ovf = 1'b1;
      end else if (e >= W) begin
         r.tag = "R2+R7";
         ovf = 1'b1;
      end else begin
         sh = W + 1 - e;
         if (sh >= MW) begin
            mg  = '0;
            lst = (m != '0) || stk;
         end else begin
            mg  = m >> sh;
            lst = ((mg << sh) != m) || stk;
         end
         if (mg > half || (mg == half && !sgn)) begin
            r.tag = "R6+R7";
            ovf = 1'b1;
         end else begin
            r.res = sgn ? W'(-mg) : W'(mg);
            r.inx = lst;
            if (mg == half)  r.tag = "R6";
            else if (sgn)    r.tag = "R8";
            else if (lst)    r.tag = "R5";
            else             r.tag = "R4";
         end
      end
      if (ovf) begin
         r.inv = 1'b1;
         r.res = sgn ? W'(half) : W'(half - 1);
      end
      return r;
   endfunction

   task automatic check(bit ok, string tag, string what, logic [W-1:0] act, logic [W-1:0] expv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   task automatic send(bit sgn, int cls, int e, logic [MW-1:0] m, bit stk);
      @(negedge clk);
      in_valid  = 1'b1;
      in_sign   = sgn;
      in_class  = 3'(cls);
      in_exp    = EXP_W'(e);
      in_mant   = m;
      in_sticky = stk;
      q.push_back(model(sgn, cls, e, m, stk));
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // Compare on every clock (falling edge, away from the register update).
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (out_valid) begin
            if (q.size() == 0) begin
               check(1'b0, "R9", "unexpected out_valid", W'(1), W'(0));
            end else begin
               exp_t e;
               e = q.pop_front();
               check(out_result == e.res, e.tag, "result", out_result, e.res);
               check(out_inexact == e.inx, e.tag, "inexact", W'(out_inexact), W'(e.inx));
               check(out_invalid == e.inv, e.tag, "invalid", W'(out_invalid), W'(e.inv));
            end
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         check(1'b0, "R9", "watchdog expired", W'(cyc), W'(0));
         finish_run();
      end
   end

   initial begin
      logic [MW-1:0] one;
      one = '0;
      one[W+1] = 1'b1;
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R9", "reset out_valid", W'(out_valid), W'(0));
      check(out_result == '0, "R9", "reset result", out_result, W'(0));
      rst_n = 1'b1;

      // R1 zero, both signs, arbitrary mantissa
      send(0, 0, 5, '1, 1);
      send(1, 0, -3, one, 0);
      // R3 specials
      send(0, 2, 0, one, 0);
      send(1, 2, 0, one, 1);
      send(0, 3, 7, '1, 0);
      send(1, 4, -9, one, 1);
      // R2 large exponents
      send(0, 1, W, one, 0);
      send(1, 1, W, one | 5, 1);
      send(0, 1, 1000, one, 0);
      // R6 around 2^(W-1)
      send(0, 1, W - 1, one, 0);
      send(1, 1, W - 1, one, 0);
      send(1, 1, W - 1, one | 1, 0);
      send(1, 1, W - 1, one, 1);
      send(1, 1, W - 1, one | 4, 0);
      // exponent W-2: largest positive with guard bits lost
      send(0, 1, W - 2, {2'b00, {(W + 2){1'b1}}}, 0);
      send(1, 1, W - 2, {2'b00, {(W + 2){1'b1}}}, 0);
      // R4 and R5 small values
      send(0, 1, 0, one, 0);
      send(0, 1, 0, one, 1);
      send(0, 1, -1, one, 0);
      send(1, 1, -1, one, 0);
      send(0, 1, -200, one, 0);
      // R8 negation
      send(1, 1, 0, one, 0);
      send(1, 1, 3, one | (MW'(1) << W), 0);
      idle();
      idle();
      // R9: result holds while idle
      check(out_valid == 1'b0, "R9", "idle out_valid", W'(out_valid), W'(0));
      check(out_result == W'(-12), "R9", "held result", out_result, W'(-12));

      for (int i = 0; i < 600; i++) begin
         logic [MW-1:0] m;
         int            cls;
         int            e;
         m = MW'({$urandom, $urandom});
         m[W+3:W+1] = 3'b001;
         cls = ($urandom_range(0, 9) < 8) ? 1 : $urandom_range(0, 4);
         e = $urandom_range(0, W + 8) - 6;
         send(1'($urandom), cls, e, m, 1'($urandom));
         if ($urandom_range(0, 7) == 0) idle();
      end
      idle();
      repeat (3) @(negedge clk);
      check(q.size() == 0, "R9", "pending results", W'(q.size()), W'(0));
      finish_run();
   end

endmodule